// File: doc/BRIEF.md
# Remote Key Code Lookup with Repeat Tracking

This block turns a decoded infrared remote-control frame into a key code. It holds a small table of remotes. Each remote slot has a 16-bit user code, a button count, and a list of button pairs. Each pair links an 8-bit scan code to a key code. The table is filled through a simple write port before lookups begin.

A lookup strobe carries a user code and a scan code. The block walks the remote slots in index order, one slot per clock, until a user code matches. It then walks only that remote's buttons, one pair per clock, until a scan code matches. When the walk ends, the block pulses `done` and updates three outputs: a hit flag, the key code and a repeat count. The repeat count grows while the same key keeps arriving, so software can tell a held button from a fresh press. Both the key code and the repeat count are held until the next lookup.

Top module: `remote_key_lookup`

## Requirements
- R1: A user-code write stores the code in the slot chosen by `tbl_remote`. A write whose data is zero is ignored, and the slot keeps its previous code.
- R2: Only the first N pairs of a remote are searched, where N is its stored button count. A pair at an index at or above the count never hits. A count written above `N_BUTTONS` is stored as `N_BUTTONS`.
- R3: The remote search takes the lowest-index slot whose user code equals the lookup's user code. Only that remote's buttons are searched, even when a later slot carries the same user code.
- R4: Within the chosen remote, pairs are compared in index order. The lowest-index pair whose scan code matches gives the key code.
- R5: On a hit, if the new key code equals the key code currently held, the repeat count increments, saturating at its all-ones value. Otherwise the repeat count becomes zero. The new key code is then held.
- R6: On a miss (no remote matches, no counted pair matches, or the count is zero), `hit` is 0, the key code becomes 0 and the repeat count becomes 0.
- R7: For each accepted lookup, `busy` rises in the cycle after the strobe. `done` is a one-cycle pulse in the first cycle after `busy` falls.
- R8: A lookup strobe that arrives while `busy` is high is ignored: it produces no second `done` and does not change the result. `hit`, `key_code` and `repeat_cnt` change only in a `done` cycle.
- R9: A lookup stays busy for at most `N_REMOTES + N_BUTTONS + 1` cycles.
- R10: Reset clears `hit`, `key_code`, `repeat_cnt`, `done` and `busy`, and empties the table: every slot has user code 0 and count 0, so every lookup misses.
- R11: A lookup with user code zero always misses, because a stored user code of zero marks an empty slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_remote | input | $clog2(N_REMOTES) | Remote slot addressed by any table write |
| tbl_code_we | input | 1 | Write strobe for the slot's user code |
| tbl_code | input | UC_W | User code to store (zero is rejected) |
| tbl_count_we | input | 1 | Write strobe for the slot's button count |
| tbl_count | input | $clog2(N_BUTTONS+1) | Button count to store |
| tbl_btn_we | input | 1 | Write strobe for one button pair |
| tbl_btn | input | $clog2(N_BUTTONS) | Button index within the slot |
| tbl_scan | input | SC_W | Scan code of the pair |
| tbl_key | input | KC_W | Key code of the pair |
| look_valid | input | 1 | Lookup strobe |
| look_user | input | UC_W | User code of the frame |
| look_scan | input | SC_W | Scan code of the frame |
| busy | output | 1 | A lookup is being walked |
| done | output | 1 | One-cycle pulse when the result is updated |
| hit | output | 1 | Last lookup found a key |
| key_code | output | KC_W | Held key code, 0 when no key |
| repeat_cnt | output | RPT_W | Held repeat count |

## Verification
The bench builds the block with four remote slots of four buttons each and a 2-bit repeat counter. Under these settings, saturation is reached after three repeats. The last slot's last button, a full button list, and a count written above the limit are all reached with a short table. The busy-cycle bound is small enough to check exactly on every lookup. The table holds deliberate duplicates: two slots share a user code, and one slot has a repeated scan code. It also holds a pair stored beyond its slot's count. These make the ordering rules and the count limit observable at the outputs.

// File: rtl/keymap_pkg.sv
package keymap_pkg;
  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_REMOTE = 2'd1,
    S_BUTTON = 2'd2
  } srch_state_t;
endpackage

// File: rtl/keymap_remote_table.sv
module keymap_remote_table #(
  parameter int N_REMOTES = 4,
  parameter int N_BUTTONS = 16,
  parameter int UC_W      = 16,
  localparam int RIDX_W   = $clog2(N_REMOTES),
  localparam int CNT_W    = $clog2(N_BUTTONS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RIDX_W-1:0] wr_idx,
  input  logic              code_we,
  input  logic [UC_W-1:0]   wr_code,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  wr_cnt,
  input  logic [RIDX_W-1:0] walk_idx,
  output logic [UC_W-1:0]   walk_code,
  input  logic [RIDX_W-1:0] sel_idx,
  output logic [CNT_W-1:0]  sel_cnt
);
  logic [UC_W-1:0]  codes [N_REMOTES];
  logic [CNT_W-1:0] cnts  [N_REMOTES];
  logic [CNT_W-1:0] cnt_lim;

  // A count above the physical list length is taken as the full list
  assign cnt_lim = (wr_cnt > CNT_W'(N_BUTTONS)) ? CNT_W'(N_BUTTONS) : wr_cnt;

  for (genvar s = 0; s < N_REMOTES; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        codes[s] <= '0;
        cnts[s]  <= '0;
      end else begin
        // zero marks an empty slot and is never stored
        if (code_we && wr_idx == RIDX_W'(s) && wr_code != '0)
          codes[s] <= wr_code;
        if (cnt_we && wr_idx == RIDX_W'(s))
          cnts[s] <= cnt_lim;
      end
    end
  end

  assign walk_code = codes[walk_idx];
  assign sel_cnt   = cnts[sel_idx];
endmodule

// File: rtl/keymap_button_mem.sv
module keymap_button_mem #(
  parameter int N_REMOTES = 4,
  parameter int N_BUTTONS = 16,
  parameter int SC_W      = 8,
  parameter int KC_W      = 16,
  localparam int RIDX_W   = $clog2(N_REMOTES),
  localparam int BIDX_W   = $clog2(N_BUTTONS),
  localparam int DEPTH    = N_REMOTES * N_BUTTONS,
  localparam int AW       = RIDX_W + BIDX_W,
  localparam int DW       = SC_W + KC_W
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // One write port and one registered read port, so the array maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/keymap_search.sv
module keymap_search
  import keymap_pkg::*;
#(
  parameter int N_REMOTES = 4,
  parameter int N_BUTTONS = 16,
  parameter int UC_W      = 16,
  parameter int SC_W      = 8,
  parameter int KC_W      = 16,
  parameter int RPT_W     = 8,
  localparam int RIDX_W   = $clog2(N_REMOTES),
  localparam int BIDX_W   = $clog2(N_BUTTONS),
  localparam int CNT_W    = $clog2(N_BUTTONS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               look_valid,
  input  logic [UC_W-1:0]    look_user,
  input  logic [SC_W-1:0]    look_scan,
  output logic [RIDX_W-1:0]  walk_idx,
  input  logic [UC_W-1:0]    walk_code,
  output logic [RIDX_W-1:0]  sel_idx,
  input  logic [CNT_W-1:0]   sel_cnt,
  output logic [BIDX_W-1:0]  btn_idx,
  input  logic [SC_W-1:0]    btn_scan,
  input  logic [KC_W-1:0]    btn_key,
  output logic               busy,
  output logic               done,
  output logic               hit,
  output logic [KC_W-1:0]    key_code,
  output logic [RPT_W-1:0]   repeat_cnt
);
  localparam logic [RPT_W-1:0]  RPT_MAX = '1;
  localparam logic [RIDX_W-1:0] LAST_R  = RIDX_W'(N_REMOTES - 1);

  srch_state_t       state;
  logic [UC_W-1:0]   user_q;
  logic [SC_W-1:0]   scan_q;
  logic [RIDX_W-1:0] r_idx;
  logic [RIDX_W-1:0] sel_q;
  logic [CNT_W-1:0]  b_cnt;
  logic              pend;

  logic              user_match;
  logic              scan_match;
  logic              fin_en;
  logic              fin_hit;
  logic [KC_W-1:0]   fin_key;

  assign walk_idx   = r_idx;
  assign sel_idx    = sel_q;
  assign btn_idx    = b_cnt[BIDX_W-1:0];
  assign busy       = (state != S_IDLE);
  assign user_match = (walk_code != '0) && (walk_code == user_q);
  assign scan_match = pend && (btn_scan == scan_q);

  always_comb begin
    fin_en  = 1'b0;
    fin_hit = 1'b0;
    fin_key = '0;
    case (state)
      S_REMOTE: if (!user_match && r_idx == LAST_R) fin_en = 1'b1;
      S_BUTTON: begin
        if (scan_match) begin
          fin_en  = 1'b1;
          fin_hit = 1'b1;
          fin_key = btn_key;
        end else if (b_cnt >= sel_cnt) begin
          fin_en = 1'b1;
        end
      end
      default: ;
    endcase
  end

  // Walk: one remote slot per cycle, then one pair per cycle with a one-deep
  // read pipeline (pair issued in one cycle is compared in the next)
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      user_q <= '0;
      scan_q <= '0;
      r_idx  <= '0;
      sel_q  <= '0;
      b_cnt  <= '0;
      pend   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (look_valid) begin
            user_q <= look_user;
            scan_q <= look_scan;
            r_idx  <= '0;
            state  <= S_REMOTE;
          end
        end
        S_REMOTE: begin
          if (user_match) begin
            sel_q <= r_idx;
            b_cnt <= '0;
            pend  <= 1'b0;
            state <= S_BUTTON;
          end else if (fin_en) begin
            state <= S_IDLE;
          end else begin
            r_idx <= r_idx + 1'b1;
          end
        end
        S_BUTTON: begin
          if (fin_en) begin
            state <= S_IDLE;
            pend  <= 1'b0;
          end else begin
            pend  <= 1'b1;
            b_cnt <= b_cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      hit        <= 1'b0;
      key_code   <= '0;
      repeat_cnt <= '0;
    end else begin
      done <= fin_en;
      if (fin_en) begin
        hit      <= fin_hit;
        key_code <= fin_key;
        if (!fin_hit || fin_key != key_code)
          repeat_cnt <= '0;
        else if (repeat_cnt != RPT_MAX)
          repeat_cnt <= repeat_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/remote_key_lookup.sv
module remote_key_lookup #(
  parameter int N_REMOTES = 4,
  parameter int N_BUTTONS = 16,
  parameter int UC_W      = 16,
  parameter int SC_W      = 8,
  parameter int KC_W      = 16,
  parameter int RPT_W     = 8,
  localparam int RIDX_W   = $clog2(N_REMOTES),
  localparam int BIDX_W   = $clog2(N_BUTTONS),
  localparam int CNT_W    = $clog2(N_BUTTONS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RIDX_W-1:0] tbl_remote,
  input  logic              tbl_code_we,
  input  logic [UC_W-1:0]   tbl_code,
  input  logic              tbl_count_we,
  input  logic [CNT_W-1:0]  tbl_count,
  input  logic              tbl_btn_we,
  input  logic [BIDX_W-1:0] tbl_btn,
  input  logic [SC_W-1:0]   tbl_scan,
  input  logic [KC_W-1:0]   tbl_key,
  input  logic              look_valid,
  input  logic [UC_W-1:0]   look_user,
  input  logic [SC_W-1:0]   look_scan,
  output logic              busy,
  output logic              done,
  output logic              hit,
  output logic [KC_W-1:0]   key_code,
  output logic [RPT_W-1:0]  repeat_cnt
);
  logic [RIDX_W-1:0]    walk_idx;
  logic [UC_W-1:0]      walk_code;
  logic [RIDX_W-1:0]    sel_idx;
  logic [CNT_W-1:0]     sel_cnt;
  logic [BIDX_W-1:0]    btn_idx;
  logic [SC_W+KC_W-1:0] pair_rd;

  keymap_remote_table #(
    .N_REMOTES(N_REMOTES), .N_BUTTONS(N_BUTTONS), .UC_W(UC_W)
  ) u_table (
    .clk(clk), .rst(rst),
    .wr_idx(tbl_remote), .code_we(tbl_code_we), .wr_code(tbl_code),
    .cnt_we(tbl_count_we), .wr_cnt(tbl_count),
    .walk_idx(walk_idx), .walk_code(walk_code),
    .sel_idx(sel_idx), .sel_cnt(sel_cnt)
  );

  keymap_button_mem #(
    .N_REMOTES(N_REMOTES), .N_BUTTONS(N_BUTTONS), .SC_W(SC_W), .KC_W(KC_W)
  ) u_pairs (
    .clk(clk),
    .we(tbl_btn_we), .waddr({tbl_remote, tbl_btn}), .wdata({tbl_scan, tbl_key}),
    .raddr({sel_idx, btn_idx}), .rdata(pair_rd)
  );

  keymap_search #(
    .N_REMOTES(N_REMOTES), .N_BUTTONS(N_BUTTONS), .UC_W(UC_W),
    .SC_W(SC_W), .KC_W(KC_W), .RPT_W(RPT_W)
  ) u_search (
    .clk(clk), .rst(rst),
    .look_valid(look_valid), .look_user(look_user), .look_scan(look_scan),
    .walk_idx(walk_idx), .walk_code(walk_code),
    .sel_idx(sel_idx), .sel_cnt(sel_cnt),
    .btn_idx(btn_idx), .btn_scan(pair_rd[SC_W+KC_W-1:KC_W]), .btn_key(pair_rd[KC_W-1:0]),
    .busy(busy), .done(done), .hit(hit), .key_code(key_code), .repeat_cnt(repeat_cnt)
  );
endmodule

// File: rtl/keymap_chk.sv
module keymap_chk #(
  parameter int N_REMOTES = 4,
  parameter int N_BUTTONS = 16,
  parameter int KC_W      = 16,
  parameter int RPT_W     = 8,
  localparam int LIMIT    = N_REMOTES + N_BUTTONS + 1,
  localparam int BW       = $clog2(LIMIT + 2)
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic             hit,
  input logic [KC_W-1:0]  key_code,
  input logic [RPT_W-1:0] repeat_cnt
);
  localparam logic [RPT_W-1:0] RPT_MAX = '1;
  logic [BW-1:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst) busy_run <= '0;
    else if (busy && busy_run != '1) busy_run <= busy_run + 1'b1;
    else if (!busy) busy_run <= '0;
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst) done |-> (!busy && $past(busy)));
  // R6
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !hit) |-> (key_code == '0 && repeat_cnt == '0));
  // R5
  new_key_chk: assert property (@(posedge clk) disable iff (rst)
    (done && hit && key_code != $past(key_code)) |-> repeat_cnt == '0);
  // R5
  repeat_step_chk: assert property (@(posedge clk) disable iff (rst)
    (done && hit && key_code == $past(key_code) && $past(repeat_cnt) != RPT_MAX)
      |-> repeat_cnt == RPT_W'($past(repeat_cnt) + 1'b1));
  // R5
  repeat_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (done && hit && key_code == $past(key_code) && $past(repeat_cnt) == RPT_MAX)
      |-> repeat_cnt == RPT_MAX);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(key_code) && $stable(repeat_cnt) && $stable(hit)));
  // R9
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_run < BW'(LIMIT)));
endmodule

bind remote_key_lookup keymap_chk #(
  .N_REMOTES(N_REMOTES), .N_BUTTONS(N_BUTTONS), .KC_W(KC_W), .RPT_W(RPT_W)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .hit(hit),
  .key_code(key_code), .repeat_cnt(repeat_cnt)
);

// File: tb/tb_remote_key_lookup.sv
`timescale 1ns/1ps
module tb_remote_key_lookup;
  localparam int NR = 4, NB = 4, UCW = 16, SCW = 8, KCW = 16, RW = 2;
  localparam int LIMIT = NR + NB + 1;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] tbl_remote = '0;
  logic tbl_code_we = 0, tbl_count_we = 0, tbl_btn_we = 0, look_valid = 0;
  logic [UCW-1:0] tbl_code = '0, look_user = '0;
  logic [2:0] tbl_count = '0;
  logic [1:0] tbl_btn = '0;
  logic [SCW-1:0] tbl_scan = '0, look_scan = '0;
  logic [KCW-1:0] tbl_key = '0;
  logic busy, done, hit;
  logic [KCW-1:0] key_code;
  logic [RW-1:0] repeat_cnt;

  int checks = 0, errors = 0, last_busy = 0;

  always #2 clk = ~clk;

  remote_key_lookup #(.N_REMOTES(NR), .N_BUTTONS(NB), .UC_W(UCW), .SC_W(SCW),
                      .KC_W(KCW), .RPT_W(RW)) dut (.*);

  // user, scan, hit, key, repeat
  localparam logic [42:0] VEC [17] = '{
    {16'h1111, 8'h10, 1'b1, 16'h0101, 2'd0},  // R4 lower duplicate wins
    {16'h1111, 8'h10, 1'b1, 16'h0101, 2'd1},  // R5
    {16'h1111, 8'h10, 1'b1, 16'h0101, 2'd2},
    {16'h1111, 8'h10, 1'b1, 16'h0101, 2'd3},
    {16'h1111, 8'h10, 1'b1, 16'h0101, 2'd3},  // R5 saturate
    {16'h1111, 8'h11, 1'b1, 16'h0102, 2'd0},  // R5 new key
    {16'h1111, 8'h30, 1'b0, 16'h0000, 2'd0},  // R3 second slot not searched
    {16'h1111, 8'h11, 1'b1, 16'h0102, 2'd0},
    {16'h2222, 8'h22, 1'b0, 16'h0000, 2'd0},  // R2 pair beyond count
    {16'h2222, 8'h21, 1'b1, 16'h0202, 2'd0},
    {16'h4444, 8'h43, 1'b1, 16'h0404, 2'd0},  // last slot, last pair
    {16'h5555, 8'h40, 1'b0, 16'h0000, 2'd0},  // R6 unknown remote
    {16'h4444, 8'h43, 1'b1, 16'h0404, 2'd0},
    {16'h0000, 8'h10, 1'b0, 16'h0000, 2'd0},  // R11
    {16'h4444, 8'h43, 1'b1, 16'h0404, 2'd0},
    {16'h4444, 8'h43, 1'b1, 16'h0404, 2'd1},
    {16'h4444, 8'h4F, 1'b0, 16'h0000, 2'd0}   // R2 clamped count, R6
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_code(input int r, input logic [15:0] c);
    @(negedge clk); tbl_remote = 2'(r); tbl_code = c; tbl_code_we = 1;
    @(negedge clk); tbl_code_we = 0;
  endtask

  task automatic wr_count(input int r, input int n);
    @(negedge clk); tbl_remote = 2'(r); tbl_count = 3'(n); tbl_count_we = 1;
    @(negedge clk); tbl_count_we = 0;
  endtask

  task automatic wr_btn(input int r, input int b, input logic [7:0] s, input logic [15:0] k);
    @(negedge clk); tbl_remote = 2'(r); tbl_btn = 2'(b); tbl_scan = s; tbl_key = k; tbl_btn_we = 1;
    @(negedge clk); tbl_btn_we = 0;
  endtask

  // pulses a lookup, waits for done (sampled at negedge), records busy cycles
  task automatic lookup(input logic [15:0] u, input logic [7:0] s);
    int n = 0;
    @(negedge clk); look_user = u; look_scan = s; look_valid = 1;
    @(negedge clk); look_valid = 0;
    while (!done && n < 100) begin
      if (busy) last_busy++;
      @(negedge clk); n++;
    end
  endtask

  task automatic expect_res(input string tag, input bit h, input logic [15:0] k, input logic [1:0] rp);
    check(done == 1'b1, {tag, " done"}, 32'(done), 1);
    check(hit == h, {tag, " hit"}, 32'(hit), 32'(h));
    check(key_code == k, {tag, " key"}, 32'(key_code), 32'(k));
    check(repeat_cnt == rp, {tag, " repeat"}, 32'(repeat_cnt), 32'(rp));
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    check(!busy && !done && !hit && key_code == 0 && repeat_cnt == 0, "R10 reset outputs",
          {busy, done, hit, key_code, 11'(repeat_cnt)}, 0);
    lookup(16'h1111, 8'h10);
    expect_res("R10 empty table", 0, 16'h0, 2'd0);

    // table load
    wr_code(0, 16'h1111); wr_count(0, 3);
    wr_btn(0, 0, 8'h10, 16'h0101); wr_btn(0, 1, 8'h11, 16'h0102); wr_btn(0, 2, 8'h10, 16'h0103);
    wr_code(1, 16'h2222); wr_count(1, 2);
    wr_btn(1, 0, 8'h20, 16'h0201); wr_btn(1, 1, 8'h21, 16'h0202); wr_btn(1, 2, 8'h22, 16'h0203);
    wr_code(2, 16'h1111); wr_count(2, 1); wr_btn(2, 0, 8'h30, 16'h0301);
    wr_code(3, 16'h4444); wr_count(3, 7);  // R2 above limit, taken as 4
    for (int b = 0; b < 4; b++) wr_btn(3, b, 8'(8'h40 + b), 16'(16'h0401 + b));

    for (int i = 0; i < 17; i++) begin
      last_busy = 0;
      lookup(VEC[i][42:27], VEC[i][26:19]);
      expect_res($sformatf("R3/R4/R5/R6 vec%0d", i), VEC[i][18], VEC[i][17:2], VEC[i][1:0]);
      check(last_busy <= LIMIT, "R9 busy bound", last_busy, LIMIT);
    end

    // R1: zero write ignored
    wr_code(3, 16'h0000);
    lookup(16'h4444, 8'h42);
    expect_res("R1 zero write ignored", 1, 16'h0403, 2'd0);

    // R7: done lasts one cycle
    @(negedge clk);
    check(done == 0, "R7 done one cycle", 32'(done), 0);

    // R7/R8: busy timing and strobe while busy ignored
    @(negedge clk); look_user = 16'h4444; look_scan = 8'h41; look_valid = 1;
    @(negedge clk);
    check(busy == 1, "R7 busy after strobe", 32'(busy), 1);
    look_user = 16'h2222; look_scan = 8'h20;
    @(negedge clk); look_valid = 0;
    begin
      int n = 0;
      while (!done && n < 100) begin @(negedge clk); n++; end
    end
    expect_res("R8 first lookup kept", 1, 16'h0402, 2'd0);
    check(busy == 0, "R7 busy low at done", 32'(busy), 0);
    begin
      int extra = 0;
      for (int c = 0; c < 20; c++) begin @(negedge clk); if (done) extra++; end
      check(extra == 0, "R8 no second done", extra, 0);
      check(key_code == 16'h0402, "R8 key held", 32'(key_code), 32'h0402);
    end

    // R10: reset empties the table
    rst = 1; @(negedge clk); @(negedge clk); rst = 0;
    check(key_code == 0 && repeat_cnt == 0 && !hit, "R10 outputs after reset",
          {hit, key_code, 13'(repeat_cnt)}, 0);
    lookup(16'h4444, 8'h43);
    expect_res("R10 table cleared", 0, 16'h0, 2'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule